// File: doc/BRIEF.md
# Complementary Output Enable and Off-State Control

This block is the last stage of one channel of a motor-control style timer. It takes three signals and turns them into two pin levels and two pin-enable (tri-state control) signals. The first is a raw reference waveform. The other two are a pair of dead-time-shaped waveforms from a separate dead-time generator. The output enable bits decide the channel mode. With both outputs enabled, the pair is driven as complementary signals with dead time. With one output enabled, the raw reference goes to that output without inversion and the other output rests. With neither enabled, both outputs rest.

The block owns the master output enable flag. Software can set or clear it with strobes. An optional automatic mode sets it again on an update-event strobe. A break input clears it at once, without waiting for a clock edge. While the master enable is low, the channel is in idle mode and the pins carry their programmed idle levels. While it is high, the channel is in run mode. In both modes a separate off-state select bit decides whether a resting output is still actively driven or released.

Top module: `compl_out_stage`

## Requirements
- R1: Each output has its own polarity bit. In run mode the pin level is the output's active state XOR its polarity bit, so 0 means active high and 1 means active low. A resting output in run mode sits at the level equal to its polarity bit.
- R2: In run mode with both output enables at 1, the main pin follows `dt_main_i`, the complementary pin follows `dt_comp_i`, and both pin-enables are 1.
- R3: In run mode with exactly one output enabled, that output is active exactly when `ref_i` is 1, without inversion, even when it is the complementary output. Its pin-enable is 1.
- R4: In run mode, a non-enabled output rests at its inactive level. Its pin-enable equals `run_off_i` AND (either enable bit set).
- R5: In idle mode, each pin carries its idle-level input. Both pin-enables equal `idle_off_i` AND (either enable bit set).
- R6: `brk_i` at 1 clears the master enable at once, without waiting for a clock edge. While it stays at 1, software set strobes and update strobes leave the master enable at 0.
- R7: A software set strobe raises the master enable at the next clock edge. A software clear strobe drops it at the next edge, and clear wins when both strobes are asserted together.
- R8: With `auto_en_i` at 1 and the break inactive, an update strobe sets the master enable at the next edge. With `auto_en_i` at 0, the update strobe has no effect.
- R9: After reset the master enable is 0, so the pins show their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_i | input | 1 | Raw reference waveform |
| dt_main_i | input | 1 | Dead-time-shaped main waveform (active high) |
| dt_comp_i | input | 1 | Dead-time-shaped complementary waveform (active high) |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main polarity, 1 = active low |
| comp_pol_i | input | 1 | Complementary polarity, 1 = active low |
| main_idle_i | input | 1 | Main pin level in idle mode |
| comp_idle_i | input | 1 | Complementary pin level in idle mode |
| run_off_i | input | 1 | Run-mode off-state select |
| idle_off_i | input | 1 | Idle-mode off-state select |
| sw_set_i | input | 1 | Software master-enable set strobe |
| sw_clr_i | input | 1 | Software master-enable clear strobe |
| auto_en_i | input | 1 | Automatic re-enable option |
| update_i | input | 1 | Update-event strobe |
| brk_i | input | 1 | Break input, active high |
| main_pin_o | output | 1 | Main pin level |
| main_oe_o | output | 1 | Main pin enable |
| comp_pin_o | output | 1 | Complementary pin level |
| comp_oe_o | output | 1 | Complementary pin enable |
| master_en_o | output | 1 | Master output enable state |

## Verification
The hardest case to reach is the break interacting with the master enable register between clock edges. The break must clear the flag at once, before any edge, and it must also block a software set or an update strobe that arrives while it is still high. The stimulus raises the break a quarter period after an edge and checks the flag and pins half a period later, before the next edge. It then keeps the break high across set and update strobes. Finally it lowers the break and shows that one later update strobe restores run mode only when the automatic option is on.

// File: rtl/cout_pkg.sv
// Package: shared constants and types for the complementary output stage.
// Assumes index 0 is the main output and index 1 the complementary output.
package cout_pkg;
    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned PIN_MAIN = 0;
    localparam int unsigned PIN_COMP = 1;

    typedef enum logic [1:0] {
        MODE_REST      = 2'b00,
        MODE_MAIN_ONLY = 2'b01,
        MODE_COMP_ONLY = 2'b10,
        MODE_PAIR      = 2'b11
    } chan_mode_e;
endpackage

// File: rtl/cout_master_en.sv
// Module: master output enable flag.
// Break clears it asynchronously. Otherwise, under the synchronous active-low
// reset, a clear strobe beats a set strobe, which beats an automatic
// re-enable on an update strobe.
// Assumes brk_i is already synchronised to, or safe against, clk by the caller.
module cout_master_en (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic auto_en_i,
    input  logic update_i,
    output logic en_o
);
    // Flag register: async clear by break, sync reset and strobes otherwise.
    always_ff @(posedge clk or posedge brk_i) begin
        if (brk_i)
            en_o <= 1'b0;
        else if (!rst_n)
            en_o <= 1'b0;
        else if (sw_clr_i)
            en_o <= 1'b0;
        else if (sw_set_i)
            en_o <= 1'b1;
        else if (auto_en_i && update_i)
            en_o <= 1'b1;
    end
endmodule

// File: rtl/cout_mode_dec.sv
// Module: channel mode decoder.
// Picks the mode from the two enable bits and gives each output its active
// drive value and whether it is selected.
// Assumes the dead-time inputs are already active-high shaped waveforms.
module cout_mode_dec
    import cout_pkg::*;
(
    input  logic                main_en_i,
    input  logic                comp_en_i,
    input  logic                ref_i,
    input  logic                dt_main_i,
    input  logic                dt_comp_i,
    output chan_mode_e          mode_o,
    output logic [NUM_PINS-1:0] sel_o,
    output logic [NUM_PINS-1:0] act_o
);
    // Mode from the enable pair.
    always_comb mode_o = chan_mode_e'({comp_en_i, main_en_i});

    // Per-output selection and active value for the current mode.
    always_comb begin
        sel_o = '0;
        act_o = '0;
        case (mode_o)
            MODE_PAIR: begin
                sel_o          = '1;
                act_o[PIN_MAIN] = dt_main_i;
                act_o[PIN_COMP] = dt_comp_i;
            end
            MODE_MAIN_ONLY: begin
                sel_o[PIN_MAIN] = 1'b1;
                act_o[PIN_MAIN] = ref_i;
            end
            MODE_COMP_ONLY: begin
                sel_o[PIN_COMP] = 1'b1;
                act_o[PIN_COMP] = ref_i;
            end
            default: begin
                sel_o = '0;
                act_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/cout_pin_drv.sv
// Module: single pin driver.
// Applies polarity, the run and idle off-state rules, and the idle level
// to one output.
// Assumes any_en_i is the OR of both output enable bits of the channel.
module cout_pin_drv (
    input  logic master_en_i,
    input  logic sel_i,
    input  logic act_i,
    input  logic pol_i,
    input  logic idle_lvl_i,
    input  logic run_off_i,
    input  logic idle_off_i,
    input  logic any_en_i,
    output logic pin_o,
    output logic oe_o
);
    // Level and pin enable for run and idle modes.
    always_comb begin
        if (master_en_i) begin
            if (sel_i) begin
                pin_o = act_i ^ pol_i;
                oe_o  = 1'b1;
            end else begin
                pin_o = pol_i;
                oe_o  = run_off_i & any_en_i;
            end
        end else begin
            pin_o = idle_lvl_i;
            oe_o  = idle_off_i & any_en_i;
        end
    end
endmodule

// File: rtl/compl_out_stage.sv
// Module: complementary output enable and off-state control for one channel.
// Holds the master enable flag and drives two pins and their enables.
// Assumes dead-time shaping happens upstream and the register decode happens
// elsewhere.
module compl_out_stage
    import cout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic dt_main_i,
    input  logic dt_comp_i,
    input  logic main_en_i,
    input  logic comp_en_i,
    input  logic main_pol_i,
    input  logic comp_pol_i,
    input  logic main_idle_i,
    input  logic comp_idle_i,
    input  logic run_off_i,
    input  logic idle_off_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic auto_en_i,
    input  logic update_i,
    input  logic brk_i,
    output logic main_pin_o,
    output logic main_oe_o,
    output logic comp_pin_o,
    output logic comp_oe_o,
    output logic master_en_o
);
    logic                master_en;
    chan_mode_e          mode;
    logic [NUM_PINS-1:0] sel;
    logic [NUM_PINS-1:0] act;
    logic [NUM_PINS-1:0] pol;
    logic [NUM_PINS-1:0] idle_lvl;
    logic [NUM_PINS-1:0] pin;
    logic [NUM_PINS-1:0] oe;
    logic                any_en;

    cout_master_en u_men (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_i     (brk_i),
        .sw_set_i  (sw_set_i),
        .sw_clr_i  (sw_clr_i),
        .auto_en_i (auto_en_i),
        .update_i  (update_i),
        .en_o      (master_en)
    );

    cout_mode_dec u_dec (
        .main_en_i (main_en_i),
        .comp_en_i (comp_en_i),
        .ref_i     (ref_i),
        .dt_main_i (dt_main_i),
        .dt_comp_i (dt_comp_i),
        .mode_o    (mode),
        .sel_o     (sel),
        .act_o     (act)
    );

    // Gather per-output configuration into indexed vectors.
    always_comb begin
        pol[PIN_MAIN]      = main_pol_i;
        pol[PIN_COMP]      = comp_pol_i;
        idle_lvl[PIN_MAIN] = main_idle_i;
        idle_lvl[PIN_COMP] = comp_idle_i;
        any_en             = (mode != MODE_REST);
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        cout_pin_drv u_drv (
            .master_en_i (master_en),
            .sel_i       (sel[g]),
            .act_i       (act[g]),
            .pol_i       (pol[g]),
            .idle_lvl_i  (idle_lvl[g]),
            .run_off_i   (run_off_i),
            .idle_off_i  (idle_off_i),
            .any_en_i    (any_en),
            .pin_o       (pin[g]),
            .oe_o        (oe[g])
        );
    end

    // Map the indexed results to the named ports.
    always_comb begin
        main_pin_o  = pin[PIN_MAIN];
        main_oe_o   = oe[PIN_MAIN];
        comp_pin_o  = pin[PIN_COMP];
        comp_oe_o   = oe[PIN_COMP];
        master_en_o = master_en;
    end
endmodule

// File: rtl/compl_out_stage_chk.sv
// Checker: temporal properties of the complementary output stage, bound to
// the top module. Assumes inputs change away from the rising clock edge.
module compl_out_stage_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_i,
    input logic dt_main_i,
    input logic dt_comp_i,
    input logic main_en_i,
    input logic comp_en_i,
    input logic main_pol_i,
    input logic comp_pol_i,
    input logic main_idle_i,
    input logic comp_idle_i,
    input logic run_off_i,
    input logic idle_off_i,
    input logic sw_set_i,
    input logic sw_clr_i,
    input logic auto_en_i,
    input logic update_i,
    input logic brk_i,
    input logic main_pin_o,
    input logic main_oe_o,
    input logic comp_pin_o,
    input logic comp_oe_o,
    input logic master_en_o
);
    assert_main_only_pol_R1: assert property (@(posedge clk) disable iff (!rst_n)
        master_en_o && main_en_i && !comp_en_i |-> main_pin_o == (ref_i ^ main_pol_i));

    assert_pair_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        master_en_o && main_en_i && comp_en_i |->
            main_pin_o == (dt_main_i ^ main_pol_i) && comp_pin_o == (dt_comp_i ^ comp_pol_i)
            && main_oe_o && comp_oe_o);

    assert_comp_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        master_en_o && comp_en_i && !main_en_i |-> comp_pin_o == (ref_i ^ comp_pol_i) && comp_oe_o);

    assert_run_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        master_en_o && !main_en_i |-> main_oe_o == (run_off_i && comp_en_i) && main_pin_o == main_pol_i);

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_o |-> main_pin_o == main_idle_i && comp_pin_o == comp_idle_i
            && main_oe_o == (idle_off_i && (main_en_i || comp_en_i))
            && comp_oe_o == (idle_off_i && (main_en_i || comp_en_i)));

    assert_brk_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i |-> !master_en_o);

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i && !sw_clr_i && !brk_i |=> master_en_o || brk_i);

    assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_i |=> !master_en_o);

    assert_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en_i && update_i && !sw_clr_i && !brk_i |=> master_en_o || brk_i);

    assert_no_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en_i && !sw_set_i && !master_en_o |=> !master_en_o);
endmodule

bind compl_out_stage compl_out_stage_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_i       (ref_i),
    .dt_main_i   (dt_main_i),
    .dt_comp_i   (dt_comp_i),
    .main_en_i   (main_en_i),
    .comp_en_i   (comp_en_i),
    .main_pol_i  (main_pol_i),
    .comp_pol_i  (comp_pol_i),
    .main_idle_i (main_idle_i),
    .comp_idle_i (comp_idle_i),
    .run_off_i   (run_off_i),
    .idle_off_i  (idle_off_i),
    .sw_set_i    (sw_set_i),
    .sw_clr_i    (sw_clr_i),
    .auto_en_i   (auto_en_i),
    .update_i    (update_i),
    .brk_i       (brk_i),
    .main_pin_o  (main_pin_o),
    .main_oe_o   (main_oe_o),
    .comp_pin_o  (comp_pin_o),
    .comp_oe_o   (comp_oe_o),
    .master_en_o (master_en_o)
);

// File: tb/test_compl_out_stage.sv
// Bench: scoreboard. The driver applies one stimulus per cycle, a quarter
// period after the rising edge, and pushes the expected outputs. The monitor
// pops and compares at the falling edge.
module test_compl_out_stage;
    typedef struct packed {
        logic refw, dtm, dtc, men, cen, mpol, cpol, midl, cidl;
        logic roff, ioff, set, clr, aut, upd, brk;
    } stim_t;

    typedef struct {
        logic [4:0] exp;   // {master_en, main_pin, main_oe, comp_pin, comp_oe}
        string      tag;
    } item_t;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    stim_t s = '0;
    item_t sb[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic main_pin, main_oe, comp_pin, comp_oe, men_o;

    always #10 clk = ~clk;

    compl_out_stage i_compl_out_stage (
        .clk (clk), .rst_n (rst_n),
        .ref_i (s.refw), .dt_main_i (s.dtm), .dt_comp_i (s.dtc),
        .main_en_i (s.men), .comp_en_i (s.cen),
        .main_pol_i (s.mpol), .comp_pol_i (s.cpol),
        .main_idle_i (s.midl), .comp_idle_i (s.cidl),
        .run_off_i (s.roff), .idle_off_i (s.ioff),
        .sw_set_i (s.set), .sw_clr_i (s.clr),
        .auto_en_i (s.aut), .update_i (s.upd), .brk_i (s.brk),
        .main_pin_o (main_pin), .main_oe_o (main_oe),
        .comp_pin_o (comp_pin), .comp_oe_o (comp_oe),
        .master_en_o (men_o)
    );

    // Expected pins from the requirements for a given master enable value.
    function automatic logic [3:0] model(stim_t x, logic me);
        logic any, pair, mp, mo, cp, co;
        any  = x.men | x.cen;
        pair = x.men & x.cen;
        if (me) begin
            if (x.men) begin mp = (pair ? x.dtm : x.refw) ^ x.mpol; mo = 1'b1; end
            else begin mp = x.mpol; mo = x.roff & any; end
            if (x.cen) begin cp = (pair ? x.dtc : x.refw) ^ x.cpol; co = 1'b1; end
            else begin cp = x.cpol; co = x.roff & any; end
        end else begin
            mp = x.midl; cp = x.cidl; mo = x.ioff & any; co = x.ioff & any;
        end
        return {mp, mo, cp, co};
    endfunction

    // Driver: apply one stimulus for a cycle and queue its expectation.
    task automatic step(input stim_t x, input logic me, input string tag);
        item_t it;
        @(posedge clk);
        #5;
        s = x;
        it.exp = {me, model(x, me)};
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare the queued expectation mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it  = sb.pop_front();
                act = {men_o, main_pin, main_oe, comp_pin, comp_oe};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        stim_t x;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        x = '0;
        step(x, 1'b0, "R9 reset idle");
        x.midl = 1; x.cidl = 1;
        step(x, 1'b0, "R9 idle levels after reset");
        x.men = 1; x.ioff = 0;
        step(x, 1'b0, "R5 idle off-state 0");
        x.ioff = 1;
        step(x, 1'b0, "R5 idle off-state 1 driven");
        x.men = 0; x.cidl = 0;
        step(x, 1'b0, "R5 idle no enables");
        x.set = 1;
        step(x, 1'b0, "R7 set strobe pending");
        x.set = 0; x.men = 1; x.cen = 1; x.dtm = 1; x.dtc = 0;
        step(x, 1'b1, "R7 set applied R2 pair main");
        x.dtm = 0; x.dtc = 1;
        step(x, 1'b1, "R2 pair comp");
        x.dtc = 0;
        step(x, 1'b1, "R2 pair dead band");
        x.mpol = 1; x.cpol = 1; x.dtm = 1;
        step(x, 1'b1, "R1 both active low");
        x.cpol = 0;
        step(x, 1'b1, "R1 mixed polarity");
        x = '0; x.men = 1; x.refw = 1; x.roff = 0;
        step(x, 1'b1, "R3 main only ref high R4 rest off");
        x.refw = 0; x.roff = 1;
        step(x, 1'b1, "R4 run off-state driven");
        x.men = 0; x.cen = 1; x.refw = 1;
        step(x, 1'b1, "R3 comp only not inverted");
        x.cpol = 1; x.mpol = 1;
        step(x, 1'b1, "R3 comp only active low");
        x.cen = 0;
        step(x, 1'b1, "R4 no enable released");
        x = '0; x.set = 1; x.clr = 1;
        step(x, 1'b1, "R7 clear and set pending");
        x.set = 0; x.clr = 0;
        step(x, 1'b0, "R7 clear wins");
        x.set = 1;
        step(x, 1'b0, "R7 set again pending");
        x.set = 0; x.men = 1; x.cen = 1; x.ioff = 1; x.midl = 1;
        step(x, 1'b1, "R7 set again applied");
        x.brk = 1;
        step(x, 1'b0, "R6 break clears before edge");
        x.set = 1;
        step(x, 1'b0, "R6 set during break");
        x.set = 0; x.aut = 1; x.upd = 1;
        step(x, 1'b0, "R6 update during break");
        x.upd = 0;
        step(x, 1'b0, "R6 still cleared");
        x.brk = 0; x.upd = 1;
        step(x, 1'b0, "R8 update pending");
        x.upd = 0;
        step(x, 1'b1, "R8 auto re-enable");
        x.aut = 0; x.clr = 1;
        step(x, 1'b1, "R7 clear pending");
        x.clr = 0; x.upd = 1;
        step(x, 1'b0, "R8 update without auto pending");
        x.upd = 0;
        step(x, 1'b0, "R8 update without auto ignored");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule